// File: doc/BRIEF.md
# Keypad Event Queue with Offset Read

This block is a sixteen-slot circular store for keypad events. A scanner upstream delivers one event per cycle at most: a 7-bit key number and a flag telling whether the key went down or came up. The block packs these into one byte and appends it behind the newest stored event. Software empties the store in one of two ways. A consuming read steps the head forward and returns the entry it lands on. An offset read returns the entry a given distance from the head and moves nothing.

When an event arrives and all sixteen slots are occupied, the event is discarded. The block then latches an overflow error and pulses a request to set the error bit of an outside status register. A stored event pulses a request to set the keypad bit of that register instead. While the outside error bit is set and the overflow latch is set, new events are dropped silently. A clear input empties the store without touching the overflow latch.

Top module: `key_event_queue`

## Requirements
- R1: After a synchronous reset, `level` is 0 and `ovf_err` is 0.
- R2: A stored byte has the press flag in bit 7, which is 1 for a key going down, and the key number in bits 6:0.
- R3: A push that is neither refused nor dropped writes behind the newest entry. It raises `key_irq_set` in the same cycle and adds one to `level` at the next edge.
- R4: A push made with `level` at 16 is dropped. `err_irq_set` is high in that cycle, `key_irq_set` stays low, `ovf_err` reads 1 from the next cycle on, and the stored entries are unchanged.
- R5: While `status_err_i` and `ovf_err` are both 1, a push changes nothing and raises neither `key_irq_set` nor `err_irq_set`.
- R6: With `level` at 0 or 1, `pop_data` is 0x00, and a pop leaves the head and `level` unchanged.
- R7: With `level` at 2 or more, `pop_data` shows the entry one slot past the head. A pop moves the head forward by one and takes one off `level`.
- R8: `peek_data` is the entry at (head + `peek_idx`) mod 16 when `peek_idx` is less than `level`, and 0x00 otherwise. It never changes state.
- R9: The head and the write position wrap modulo 16, so order is kept across the wrap.
- R10: A push and a pop that both take effect in one cycle leave `level` unchanged. A push while full is judged against the count before the pop, so it is dropped even if a pop happens in the same cycle.
- R11: `cfg_clear` sets the head and `level` to 0 at the next edge. It overrides any push or pop in that cycle, raises no set request, and leaves `ovf_err` unchanged.
- R12: Only the reset clears `ovf_err`. Once set, it stays 1 through clears, pops and later pushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | 1 | Offer one key event this cycle |
| push_code | input | 7 | Key number of the offered event |
| push_press | input | 1 | 1 for a key going down, 0 for a key coming up |
| status_err_i | input | 1 | Error bit of the outside status register |
| pop_en | input | 1 | Consuming read this cycle |
| pop_data | output | 8 | Byte returned by a consuming read in this cycle |
| peek_idx | input | 4 | Offset from the head for the offset read |
| peek_data | output | 8 | Byte at the offset, or 0x00 when the offset is not below `level` |
| cfg_clear | input | 1 | Empty the queue at the next edge |
| level | output | 5 | Number of stored entries, 0 to 16 |
| ovf_err | output | 1 | Overflow error latch |
| key_irq_set | output | 1 | Request to set the keypad status bit, combinational |
| err_irq_set | output | 1 | Request to set the error status bit, combinational |

## Verification
The assertions assume that `status_err_i` follows an outside register. That register can hold its error bit while the overflow latch is clear, so the two are not tied together. They also assume that the read outputs are sampled in the same cycle as `pop_en`. The stimulus drives `status_err_i` freely, both directed and at random, including while the queue is full and the latch is set. It keeps `peek_idx` within its four bits and raises `cfg_clear` together with pushes and pops. Pushes are offered in every cycle of the fill and overflow phases, so the window in which the refusal condition holds is exercised repeatedly.

// File: rtl/kfq_pkg.sv
package kfq_pkg;

    localparam int KEY_W = 7;
    localparam int EV_W  = KEY_W + 1;

    typedef struct packed {
        logic             pressed;
        logic [KEY_W-1:0] code;
    } key_ev_t;

    typedef enum logic [1:0] {
        PUSH_IDLE,
        PUSH_TAKE,
        PUSH_DROP,
        PUSH_MUTE
    } push_act_t;

    function automatic key_ev_t make_ev(input logic pressed, input logic [KEY_W-1:0] code);
        key_ev_t ev;
        ev.pressed = pressed;
        ev.code    = code;
        return ev;
    endfunction

endpackage

// File: rtl/kfq_store.sv
module kfq_store
    import kfq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  key_ev_t           wr_data,
    input  logic [ADDR_W-1:0] rd_addr [2],
    output key_ev_t           rd_data [2]
);
    localparam int DEPTH = 1 << ADDR_W;

    key_ev_t slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        assign rd_data[p] = slots[rd_addr[p]];
    end

endmodule

// File: rtl/kfq_ctrl.sv
module kfq_ctrl
    import kfq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push_en,
    input  logic              status_err,
    input  logic              pop_en,
    input  logic [ADDR_W-1:0] peek_idx,
    output logic [ADDR_W:0]   level,
    output logic              ovf,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] pop_addr,
    output logic [ADDR_W-1:0] peek_addr,
    output logic              pop_valid,
    output logic              peek_valid,
    output logic              key_set,
    output logic              err_set
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] FULL = (ADDR_W + 1)'(DEPTH);

    logic [ADDR_W-1:0] head;
    push_act_t         act;
    logic              pop_go;

    always_comb begin
        if (rst || clr || !push_en) begin
            act = PUSH_IDLE;
        end else if (status_err && ovf) begin
            act = PUSH_MUTE;
        end else if (level == FULL) begin
            act = PUSH_DROP;
        end else begin
            act = PUSH_TAKE;
        end
    end

    assign pop_valid  = level > (ADDR_W + 1)'(1);
    assign pop_go     = pop_en && pop_valid && !clr && !rst;
    assign peek_valid = {1'b0, peek_idx} < level;
    assign pop_addr   = head + ADDR_W'(1);
    assign peek_addr  = head + peek_idx;
    assign wr_addr    = head + level[ADDR_W-1:0];
    assign wr_en      = (act == PUSH_TAKE);
    assign key_set    = (act == PUSH_TAKE);
    assign err_set    = (act == PUSH_DROP);

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            level <= '0;
            ovf   <= 1'b0;
        end else if (clr) begin
            head  <= '0;
            level <= '0;
        end else begin
            if (act == PUSH_DROP) begin
                ovf <= 1'b1;
            end
            if (pop_go) begin
                head <= head + ADDR_W'(1);
            end
            case ({wr_en, pop_go})
                2'b10:   level <= level + (ADDR_W + 1)'(1);
                2'b01:   level <= level - (ADDR_W + 1)'(1);
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
    import kfq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_en,
    input  logic [KEY_W-1:0]  push_code,
    input  logic              push_press,
    input  logic              status_err_i,
    input  logic              pop_en,
    output logic [EV_W-1:0]   pop_data,
    input  logic [ADDR_W-1:0] peek_idx,
    output logic [EV_W-1:0]   peek_data,
    input  logic              cfg_clear,
    output logic [ADDR_W:0]   level,
    output logic              ovf_err,
    output logic              key_irq_set,
    output logic              err_irq_set
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr [2];
    key_ev_t           rd_data [2];
    logic              pop_valid;
    logic              peek_valid;

    kfq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .clr        (cfg_clear),
        .push_en    (push_en),
        .status_err (status_err_i),
        .pop_en     (pop_en),
        .peek_idx   (peek_idx),
        .level      (level),
        .ovf        (ovf_err),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .pop_addr   (rd_addr[0]),
        .peek_addr  (rd_addr[1]),
        .pop_valid  (pop_valid),
        .peek_valid (peek_valid),
        .key_set    (key_irq_set),
        .err_set    (err_irq_set)
    );

    kfq_store #(.ADDR_W(ADDR_W)) store_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (make_ev(push_press, push_code)),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign pop_data  = pop_valid  ? rd_data[0] : '0;
    assign peek_data = peek_valid ? rd_data[1] : '0;

endmodule

// File: rtl/kfq_chk.sv
module kfq_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              push_en,
    input logic              status_err_i,
    input logic              pop_en,
    input logic [7:0]        pop_data,
    input logic [ADDR_W-1:0] peek_idx,
    input logic [7:0]        peek_data,
    input logic              cfg_clear,
    input logic [ADDR_W:0]   level,
    input logic              ovf_err,
    input logic              key_irq_set,
    input logic              err_irq_set
);
    localparam int DEPTH = 1 << ADDR_W;

    // R3
    grow_on_take_chk: assert property (@(posedge clk) disable iff (rst)
        (key_irq_set && !(pop_en && level > 1)) |=> (level == $past(level) + 1));

    // R4
    drop_only_full_chk: assert property (@(posedge clk) disable iff (rst)
        err_irq_set |-> (level == DEPTH && !key_irq_set));

    // R4
    drop_latches_chk: assert property (@(posedge clk) disable iff (rst)
        err_irq_set |=> ovf_err);

    // R5
    muted_push_chk: assert property (@(posedge clk) disable iff (rst)
        (status_err_i && ovf_err) |-> (!key_irq_set && !err_irq_set));

    // R6
    short_pop_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_en && level <= 1) |-> (pop_data == 8'h00));

    // R8
    peek_beyond_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, peek_idx} >= level) |-> (peek_data == 8'h00));

    // R11
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_clear |=> (level == 0));

    // R12
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err);

endmodule

bind key_event_queue kfq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .push_en      (push_en),
    .status_err_i (status_err_i),
    .pop_en       (pop_en),
    .pop_data     (pop_data),
    .peek_idx     (peek_idx),
    .peek_data    (peek_data),
    .cfg_clear    (cfg_clear),
    .level        (level),
    .ovf_err      (ovf_err),
    .key_irq_set  (key_irq_set),
    .err_irq_set  (err_irq_set)
);

// File: tb/key_event_queue_tb_top.sv
module key_event_queue_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       push_en = 1'b0;
    logic [6:0] push_code = '0;
    logic       push_press = 1'b0;
    logic       status_err_i = 1'b0;
    logic       pop_en = 1'b0;
    logic [7:0] pop_data;
    logic [3:0] peek_idx = '0;
    logic [7:0] peek_data;
    logic       cfg_clear = 1'b0;
    logic [4:0] level;
    logic       ovf_err;
    logic       key_irq_set;
    logic       err_irq_set;

    int checks = 0;
    int errors = 0;

    // reference model
    logic [7:0] m_mem [16];
    int         m_head = 0;
    int         m_cnt  = 0;
    bit         m_ovf  = 0;

    always #10 clk = ~clk;

    key_event_queue dut_i (
        .clk          (clk),
        .rst          (rst),
        .push_en      (push_en),
        .push_code    (push_code),
        .push_press   (push_press),
        .status_err_i (status_err_i),
        .pop_en       (pop_en),
        .pop_data     (pop_data),
        .peek_idx     (peek_idx),
        .peek_data    (peek_data),
        .cfg_clear    (cfg_clear),
        .level        (level),
        .ovf_err      (ovf_err),
        .key_irq_set  (key_irq_set),
        .err_irq_set  (err_irq_set)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one cycle: drive, check combinational outputs, advance the model, check state
    task automatic step(input bit push, input logic [6:0] code, input bit press,
                        input bit serr, input bit pop, input int idx,
                        input bit clr, input bit rs, input string tag);
        bit blocked, take, drop, popok;
        int e_pop, e_peek;
        @(negedge clk);
        push_en = push; push_code = code; push_press = press;
        status_err_i = serr; pop_en = pop; peek_idx = 4'(idx);
        cfg_clear = clr; rst = rs;
        #1;
        blocked = serr && m_ovf;
        take = push && !blocked && m_cnt < 16 && !clr && !rs;
        drop = push && !blocked && m_cnt == 16 && !clr && !rs;
        popok = pop && m_cnt > 1 && !clr && !rs;
        if (!rs) begin
            e_pop  = (m_cnt > 1) ? int'(m_mem[(m_head + 1) % 16]) : 0;
            e_peek = (idx < m_cnt) ? int'(m_mem[(m_head + idx) % 16]) : 0;
            check((m_cnt > 1) ? "R7 pop_data" : "R6 pop_data", int'(pop_data), e_pop);
            check("R8 peek_data", int'(peek_data), e_peek);
            check(blocked ? "R5 key_irq_set" : "R3 key_irq_set", int'(key_irq_set), int'(take));
            check(blocked ? "R5 err_irq_set" : "R4 err_irq_set", int'(err_irq_set), int'(drop));
        end
        @(posedge clk);
        if (rs) begin
            m_head = 0; m_cnt = 0; m_ovf = 0;
        end else if (clr) begin
            m_head = 0; m_cnt = 0;
        end else begin
            if (take) m_mem[(m_head + m_cnt) % 16] = {press, code};
            if (drop) m_ovf = 1;
            if (popok) m_head = (m_head + 1) % 16;
            m_cnt = m_cnt + int'(take) - int'(popok);
        end
        #1;
        check({tag, " level"}, int'(level), m_cnt);
        check({tag, " ovf_err"}, int'(ovf_err), int'(m_ovf));
    endtask

    task automatic idle(input string tag);
        step(0, 7'h0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        fork
            begin
                #3000000;
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none

        // R1: reset state
        step(0, 7'h0, 0, 0, 0, 0, 0, 1, "R1");
        step(0, 7'h0, 0, 0, 0, 0, 0, 1, "R1");
        check("R1 level after reset", int'(level), 0);
        check("R1 ovf_err after reset", int'(ovf_err), 0);

        // R2 / R3: three events and their packed format
        step(1, 7'h3c, 1, 0, 0, 0, 0, 0, "R3");
        step(1, 7'h55, 0, 0, 0, 0, 0, 0, "R3");
        step(1, 7'h01, 1, 0, 0, 0, 0, 0, "R3");
        step(0, 7'h0, 0, 0, 0, 0, 0, 0, "R2");
        check("R2 press entry", int'(peek_data), 8'hbc);
        step(0, 7'h0, 0, 0, 0, 1, 0, 0, "R2");
        check("R2 release entry", int'(peek_data), 8'h55);
        step(0, 7'h0, 0, 0, 0, 3, 0, 0, "R8");
        check("R8 peek past level", int'(peek_data), 0);

        // R6 / R7: pops down to one entry and one more
        step(0, 7'h0, 0, 0, 1, 0, 0, 0, "R7");
        step(0, 7'h0, 0, 0, 1, 0, 0, 0, "R7");
        step(0, 7'h0, 0, 0, 1, 0, 0, 0, "R6");
        check("R6 level stays at one", int'(level), 1);

        // R4: fill to sixteen then overflow
        for (int k = 0; k < 15; k++) step(1, 7'(k + 16), k[0], 0, 0, k % 16, 0, 0, "R3");
        step(1, 7'h7f, 1, 0, 0, 15, 0, 0, "R4");
        check("R4 overflow latched", int'(ovf_err), 1);
        // R5: refused while outside error bit set
        step(1, 7'h22, 1, 1, 0, 0, 0, 0, "R5");
        step(1, 7'h23, 1, 1, 0, 0, 0, 0, "R5");
        // R4: outside bit cleared, still full, drops again
        step(1, 7'h24, 0, 0, 0, 0, 0, 0, "R4");

        // R10: full with push and pop together
        step(1, 7'h25, 1, 0, 1, 2, 0, 0, "R10");
        check("R10 full push with pop", int'(level), 15);
        step(1, 7'h26, 1, 0, 1, 5, 0, 0, "R10");
        check("R10 level unchanged", int'(level), 15);

        // R9: run the head around the ring
        for (int k = 0; k < 40; k++) step(1, 7'(k), 1, 0, 1, k % 16, 0, 0, "R9");
        for (int k = 0; k < 10; k++) step(0, 7'h0, 0, 0, 1, k, 0, 0, "R9");

        // R11: clear beats push and keeps the latch
        step(1, 7'h11, 1, 0, 1, 0, 1, 0, "R11");
        check("R11 level cleared", int'(level), 0);
        check("R11 latch kept", int'(ovf_err), 1);
        idle("R12");
        check("R12 latch survives", int'(ovf_err), 1);

        // R12: reset clears the latch
        step(0, 7'h0, 0, 0, 0, 0, 0, 1, "R12");
        check("R12 latch cleared", int'(ovf_err), 0);

        // mixed traffic
        for (int k = 0; k < 600; k++) begin
            int r;
            r = $urandom_range(0, 99);
            step(r < 60, 7'($urandom), 1'($urandom), $urandom_range(0, 3) == 0,
                 $urandom_range(0, 99) < 40, $urandom_range(0, 15),
                 $urandom_range(0, 99) == 0, 0, "R10");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule